// File: doc/BRIEF.md
# BCD Calendar Clock with Battery-Backed Memory

This block is a byte-wide memory with a BCD time-of-day calendar clock at its top. A single synchronous bus port reaches every byte. Addresses below the clock window are ordinary read/write storage. The top eight byte addresses hold one control register and seven calendar counters. A one-cycle `tick` pulse, once per second, advances the calendar. The tick carries through seconds, minutes, hours, day of month, month and year. The weekday steps on the same carry as the day of month.

Software uses two control bits. One bit holds the counters so that software can load a new time through ordinary bus writes. The other bit captures a consistent copy of the calendar so that software can read all seven fields without a rollover between two reads, while timekeeping goes on underneath.

The size of the space is set by the parameter `ADDR_W`. With `ADDR_W = 13` the space is 8 KB and the clock window is 0x1FF8..0x1FFF. The default `ADDR_W = 11` gives a 2 KB space with the window at 0x7F8..0x7FF and the same behaviour.

Top module: `bcd_tod_nvram`

## Requirements
- R1: Every address below the top eight is plain memory. A write stores `bus_wdata`. A read returns the stored byte on `bus_rdata` one clock after the request.
- R2: The window sits at the top eight addresses. In rising order of the three low address bits, from 0 to 7, the window holds: control, seconds, minutes, hours, weekday, day of month, month, year. Window reads have the same one-clock latency as memory reads.
- R3: After reset the control register reads 0x00. The calendar then reads seconds 00, minutes 00, hours 00, weekday 1, day 01, month 01 and year 00.
- R4: Seconds and minutes count 00..59 in BCD. A tick at 59 returns the field to 00 and carries into the next field.
- R5: Hours count 00..23 in BCD. The carry out of 23 advances both the day of month and the weekday. The weekday counts 1..7 and returns from 7 to 1.
- R6: The day of month returns to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. In month 02 it returns after 29 when the year is divisible by four, counting 00 as divisible, and after 28 otherwise.
- R7: The month returns from 12 to 01 and carries into the year. The year counts 00..99 in BCD and returns to 00.
- R8: While control bit 7 is 1, the calendar ignores ticks. A bus write to window offsets 1..7 then loads that field directly. After bit 7 returns to 0, counting resumes from the loaded values, and ticks received during the hold are lost.
- R9: While control bit 7 is 0, bus writes to window offsets 1..7 leave the calendar unchanged.
- R10: A control write that sets bit 6 while bit 6 is 0 copies the live calendar as it stood before that clock edge. Any tick in the same cycle is not in the copy. While bit 6 is 1, reads of offsets 1..7 return the copy and counting continues. After bit 6 is cleared, reads return the live values again.
- R11: Control bits 5..0 read as 0 whatever was written to them. Bits 7 and 6 read back as written.
- R12: A loaded field is not checked. On a tick, a field at or above its last value returns to its first value and carries. Otherwise a field whose low digit is 9 or more gets low digit 0 and its high digit plus one. For example, seconds 0x5C go to 0x00 with a carry, and seconds 0x1B go to 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle pulse per elapsed second |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after the read request |

## Verification
A second tick and a control write can fall in the same clock cycle. The case that matters is the write that sets the freeze bit: it must capture the calendar from before the tick, while the live counters take the tick. The bench drives `tick` in the same cycle as the control write of 0x40. It then checks that the frozen seconds equal the pre-tick model value, and that the live seconds show the increment once the freeze is cleared. A second collision is a tick arriving in the cycle that clears the hold bit. That tick must be discarded, because the hold is still set during that cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int BYTE_W   = 8;
  localparam int WIN_REGS = 8;
  localparam int WIN_IX_W = $clog2(WIN_REGS);

  typedef enum logic [WIN_IX_W-1:0] {
    IX_CTRL = 3'd0,
    IX_SEC  = 3'd1,
    IX_MIN  = 3'd2,
    IX_HOUR = 3'd3,
    IX_WDAY = 3'd4,
    IX_MDAY = 3'd5,
    IX_MON  = 3'd6,
    IX_YEAR = 3'd7
  } win_ix_e;

  typedef struct packed {
    logic [BYTE_W-1:0] year;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] mday;
    logic [BYTE_W-1:0] wday;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] sec;
  } tod_t;

  localparam tod_t TOD_RST = '{year: 8'h00, mon: 8'h01, mday: 8'h01,
                               wday: 8'h01, hour: 8'h00, min: 8'h00,
                               sec: 8'h00};

  // one BCD increment: low digit 9 or above rolls into the high digit
  function automatic logic [BYTE_W-1:0] bcd_step(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of month; leap when (10*hi + lo) mod 4 == 0, i.e. (2*hi[0] + lo) mod 4
  function automatic logic [BYTE_W-1:0] mday_last(input logic [BYTE_W-1:0] mon,
                                                  input logic [BYTE_W-1:0] year);
    logic [1:0] rem4;
    rem4 = {year[4], 1'b0} + year[1:0];
    case (mon)
      8'h02:                      return (rem4 == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/tod_ram.sv
module tod_ram #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int RESERVED = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = (2 ** AW) - RESERVED;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rd_q <= mem_q[addr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/tod_counters.sv
module tod_counters
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ld_en,
  input  logic [WIN_IX_W-1:0] ld_ix,
  input  logic [BYTE_W-1:0] ld_data,
  output tod_t              now_o
);
  tod_t cur_q, cur_d;
  logic c_sec, c_min, c_hour, c_mday, c_mon;
  logic upd_en;

  always_comb begin
    c_sec  = tick_en && (cur_q.sec  >= 8'h59);
    c_min  = c_sec   && (cur_q.min  >= 8'h59);
    c_hour = c_min   && (cur_q.hour >= 8'h23);
    c_mday = c_hour  && (cur_q.mday >= mday_last(cur_q.mon, cur_q.year));
    c_mon  = c_mday  && (cur_q.mon  >= 8'h12);
  end

  always_comb begin
    cur_d = cur_q;
    if (ld_en) begin
      case (ld_ix)
        IX_SEC:  cur_d.sec  = ld_data;
        IX_MIN:  cur_d.min  = ld_data;
        IX_HOUR: cur_d.hour = ld_data;
        IX_WDAY: cur_d.wday = ld_data;
        IX_MDAY: cur_d.mday = ld_data;
        IX_MON:  cur_d.mon  = ld_data;
        IX_YEAR: cur_d.year = ld_data;
        default: cur_d = cur_q;
      endcase
    end else if (tick_en) begin
      cur_d.sec = c_sec ? 8'h00 : bcd_step(cur_q.sec);
      if (c_sec) cur_d.min = c_min ? 8'h00 : bcd_step(cur_q.min);
      if (c_min) cur_d.hour = c_hour ? 8'h00 : bcd_step(cur_q.hour);
      if (c_hour) begin
        cur_d.mday = c_mday ? 8'h01 : bcd_step(cur_q.mday);
        cur_d.wday = (cur_q.wday >= 8'd7) ? 8'd1 : cur_q.wday + 8'd1;
      end
      if (c_mday) cur_d.mon = c_mon ? 8'h01 : bcd_step(cur_q.mon);
      if (c_mon) cur_d.year = (cur_q.year >= 8'h99) ? 8'h00 : bcd_step(cur_q.year);
    end
  end

  assign upd_en = ld_en || tick_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= TOD_RST;
    else if (upd_en) cur_q <= cur_d;
  end

  assign now_o = cur_q;

  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld_en && cur_q.sec == 8'h59) |=> (cur_q.sec == 8'h00));

  // R5
  wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld_en && cur_q.wday >= 8'd1 && cur_q.wday <= 8'd7)
      |=> (cur_q.wday >= 8'd1 && cur_q.wday <= 8'd7));

  // R6
  short_month_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld_en && cur_q.sec == 8'h59 && cur_q.min == 8'h59 &&
     cur_q.hour == 8'h23 && cur_q.mday == 8'h30 && cur_q.mon == 8'h04)
      |=> (cur_q.mday == 8'h01 && cur_q.mon == 8'h05));

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_en) |=> $stable(cur_q));
endmodule

// File: rtl/bcd_tod_nvram.sv
module bcd_tod_nvram
  import tod_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  localparam int HI_W = ADDR_W - WIN_IX_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // decode
  logic                in_win, wr_req, rd_req, ctrl_wr, ld_en, tick_en, snap_cap;
  logic [WIN_IX_W-1:0] win_ix;
  assign in_win  = (bus_addr[ADDR_W-1:WIN_IX_W] == {HI_W{1'b1}});
  assign win_ix  = bus_addr[WIN_IX_W-1:0];
  assign wr_req  = bus_sel && bus_we;
  assign rd_req  = bus_sel && !bus_we;

  // control bits
  logic hold_q, hold_d, frz_q, frz_d;
  assign ctrl_wr  = wr_req && in_win && (win_ix == IX_CTRL);
  assign ld_en    = wr_req && in_win && (win_ix != IX_CTRL) && hold_q;
  assign tick_en  = tick && !hold_q;
  assign snap_cap = ctrl_wr && bus_wdata[6] && !frz_q;

  always_comb begin
    hold_d = ctrl_wr ? bus_wdata[7] : hold_q;
    frz_d  = ctrl_wr ? bus_wdata[6] : frz_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      hold_q <= 1'b0;
      frz_q  <= 1'b0;
    end else if (ctrl_wr) begin
      hold_q <= hold_d;
      frz_q  <= frz_d;
    end
  end

  // calendar
  tod_t live, snap_q, view;
  tod_counters u_cnt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .tick_en (tick_en),
    .ld_en   (ld_en),
    .ld_ix   (win_ix),
    .ld_data (bus_wdata),
    .now_o   (live)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)      snap_q <= TOD_RST;
    else if (snap_cap) snap_q <= live;
  end

  assign view = frz_q ? snap_q : live;

  // storage below the window
  logic [7:0] ram_rd;
  tod_ram #(.AW(ADDR_W), .DW(BYTE_W), .RESERVED(WIN_REGS)) u_ram (
    .clk   (clk),
    .we    (wr_req && !in_win),
    .re    (rd_req && !in_win),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (ram_rd)
  );

  // window read path
  logic [7:0] win_rd_d, win_rd_q;
  logic       win_sel_q;
  always_comb begin
    case (win_ix)
      IX_CTRL: win_rd_d = {hold_q, frz_q, 6'b0};
      IX_SEC:  win_rd_d = view.sec;
      IX_MIN:  win_rd_d = view.min;
      IX_HOUR: win_rd_d = view.hour;
      IX_WDAY: win_rd_d = view.wday;
      IX_MDAY: win_rd_d = view.mday;
      IX_MON:  win_rd_d = view.mon;
      default: win_rd_d = view.year;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      win_sel_q <= 1'b0;
      win_rd_q  <= 8'h00;
    end else if (rd_req) begin
      win_sel_q <= in_win;
      win_rd_q  <= win_rd_d;
    end
  end

  assign bus_rdata = win_sel_q ? win_rd_q : ram_rd;

  // R10
  snap_cap_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    snap_cap |=> (snap_q == $past(live)));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (hold_q && !ld_en) |=> $stable(live));

  // R9
  nohold_ignore_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_req && in_win && (win_ix != IX_CTRL) && !hold_q && !tick) |=> $stable(live));

  // R11
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_req && in_win && (win_ix == IX_CTRL)) |=> (bus_rdata[5:0] == 6'b0));
endmodule

// File: tb/bcd_tod_nvram_test.sv
module bcd_tod_nvram_test;
  localparam int AW = 11;
  localparam logic [AW-1:0] WIN = 11'h7F8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = 8'h00;
  logic [7:0]    bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state (decimal)
  int ms, mm, mh, mw, md, mo, my;

  always #10 clk = ~clk;

  bcd_tod_nvram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_adv();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mw = (mw == 7) ? 1 : mw + 1;
          md++;
          if (md > mlen(mo, my)) begin
            md = 1; mo++;
            if (mo == 13) begin mo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_time(input string req);
    logic [7:0] v;
    rd(WIN + 1, v); chk(req, v, bcd(ms));
    rd(WIN + 2, v); chk(req, v, bcd(mm));
    rd(WIN + 3, v); chk(req, v, bcd(mh));
    rd(WIN + 4, v); chk(req, v, bcd(mw));
    rd(WIN + 5, v); chk(req, v, bcd(md));
    rd(WIN + 6, v); chk(req, v, bcd(mo));
    rd(WIN + 7, v); chk(req, v, bcd(my));
  endtask

  task automatic load_time(input int s, input int m, input int h, input int w,
                           input int d, input int mon, input int y);
    wr(WIN, 8'h80);
    wr(WIN + 1, bcd(s)); wr(WIN + 2, bcd(m)); wr(WIN + 3, bcd(h));
    wr(WIN + 4, bcd(w)); wr(WIN + 5, bcd(d)); wr(WIN + 6, bcd(mon));
    wr(WIN + 7, bcd(y));
    wr(WIN, 8'h00);
    ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] frozen;
    int years[7] = '{0, 1, 2, 3, 4, 96, 99};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset state, R2 window order
    ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mo = 1; my = 0;
    rd(WIN, v); chk("R3 ctrl", v, 8'h00);
    chk_time("R3 R2 reset calendar");

    // R1 memory sweep
    for (int a = 0; a < int'(WIN); a++) wr(AW'(a), 8'(a) ^ 8'(a >> 3));
    for (int a = 0; a < int'(WIN); a++) begin
      rd(AW'(a), v);
      chk("R1 ram", v, 8'(a) ^ 8'(a >> 3));
    end
    chk_time("R1 ram writes leave calendar");

    // R4 R5 seconds/minutes/hours counting over 3700 ticks
    for (int i = 0; i < 3700; i++) begin
      tk(); model_adv();
      rd(WIN + 1, v); chk("R4 sec", v, bcd(ms));
      rd(WIN + 2, v); chk("R4 min", v, bcd(mm));
      rd(WIN + 3, v); chk("R5 hour", v, bcd(mh));
    end

    // R5 R6 R7 month ends across years
    foreach (years[k]) begin
      for (int mon = 1; mon <= 12; mon++) begin
        load_time(59, 59, 23, 7, mlen(mon, years[k]) - 1, mon, years[k]);
        tk(); model_adv();
        chk_time("R6 day before month end");
        load_time(59, 59, 23, 7, mlen(mon, years[k]), mon, years[k]);
        tk(); model_adv();
        chk_time("R5 R6 R7 month end rollover");
      end
    end

    // R8 hold: ticks lost, loads visible, resume from loaded value
    load_time(10, 20, 5, 3, 15, 6, 50);
    wr(WIN, 8'h80);
    tk(); tk(); tk();
    rd(WIN + 1, v); chk("R8 ticks ignored while held", v, 8'h10);
    wr(WIN + 1, 8'h30);
    rd(WIN + 1, v); chk("R8 load while held", v, 8'h30);
    // tick in the same cycle as the hold release is still discarded
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = WIN; bus_wdata = 8'h00; tick = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; tick = 1'b0;
    rd(WIN + 1, v); chk("R8 release-cycle tick dropped", v, 8'h30);
    tk();
    rd(WIN + 1, v); chk("R8 resume from loaded", v, 8'h31);
    ms = 31;

    // R9 writes ignored without hold
    wr(WIN + 1, 8'h45);
    wr(WIN + 6, 8'h09);
    rd(WIN + 1, v); chk("R9 sec write ignored", v, bcd(ms));
    rd(WIN + 6, v); chk("R9 month write ignored", v, bcd(mo));

    // R10 freeze with a tick in the same cycle
    frozen = bcd(ms);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = WIN; bus_wdata = 8'h40; tick = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; tick = 1'b0;
    model_adv();
    rd(WIN + 1, v); chk("R10 frozen pre-tick copy", v, frozen);
    tk(); model_adv(); tk(); model_adv();
    rd(WIN + 1, v); chk("R10 copy stays while counting", v, frozen);
    rd(WIN, v); chk("R10 ctrl reads freeze bit", v, 8'h40);
    wr(WIN, 8'h00);
    chk_time("R10 live after release");

    // R11 low control bits
    wr(WIN, 8'hFF);
    rd(WIN, v); chk("R11 ctrl low bits zero", v, 8'hC0);
    wr(WIN, 8'h3F);
    rd(WIN, v); chk("R11 ctrl only low bits written", v, 8'h00);

    // R12 out-of-range digits
    load_time(0, 10, 3, 2, 5, 5, 20);
    wr(WIN, 8'h80); wr(WIN + 1, 8'h5C); wr(WIN, 8'h00);
    tk();
    rd(WIN + 1, v); chk("R12 sec 5C wraps", v, 8'h00);
    rd(WIN + 2, v); chk("R12 carry into min", v, 8'h11);
    wr(WIN, 8'h80); wr(WIN + 1, 8'h1B); wr(WIN, 8'h00);
    tk();
    rd(WIN + 1, v); chk("R12 sec 1B steps to 20", v, 8'h20);
    wr(WIN, 8'h80); wr(WIN + 4, 8'h0A); wr(WIN + 1, 8'h59);
    wr(WIN + 2, 8'h59); wr(WIN + 3, 8'h23); wr(WIN, 8'h00);
    tk();
    rd(WIN + 4, v); chk("R12 weekday 0A returns to 1", v, 8'h01);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule